// File: doc/BRIEF.md
# SAR Conversion Control Sequencer

This block is the digital controller of a successive-approximation converter with an eight-way input selector. A read/convert select and a chip enable start a conversion together. The block then waits a fixed acquisition window, so that the selected input can settle and be sampled. After that it resolves the result one bit per clock, MSB first. Each trial code goes out to an external DAC and comparator, and one comparator bit comes back for each step. The comparator, DAC and sampling front end are not part of the block.

A conversion begins at the moment the two start controls first agree. The control that reaches its active state last triggers the start, and both may change in the same cycle. Once a conversion has begun, it always runs to completion. Further start attempts are ignored, and so is any attempt to change the channel. The parallel result bus is driven only while read is selected and the chip is enabled. It shows the last completed result, and a new result replaces it only when its conversion is done. A channel address is captured on a falling edge of the address strobe and drives the channel-select output.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A conversion starts at the clock edge where the condition (rd_conv_n = 0 and chip_en = 1) is sampled true after being false the cycle before. Either input may complete the condition, or both may change together. Neither input alone starts a conversion.
- R2: busy and step_en rise after the start edge. They stay high for exactly ACQ_CYCLES + WIDTH cycles, then fall.
- R3: While busy is high, new start conditions have no effect and the conversion length is unchanged. After completion, a start condition that is still held does not start a new conversion; a fresh false-to-true transition is needed.
- R4: At the start edge the trial code is cleared to all zeros. It stays zero through the acquisition window. The first trial code has only bit WIDTH-1 set.
- R5: At each step the current trial bit is kept if cmp_ge is 1 (input at or above the trial code) and is cleared otherwise. The next lower bit is then set to 1. For an ideal comparator the final result equals the input code.
- R6: dout_en is 1 exactly when rd_conv_n = 1 and chip_en = 1. dout carries the stored result when dout_en is 1 and is all zeros otherwise.
- R7: The stored result changes only at the end of a conversion. During a conversion, a read returns the previous result.
- R8: When idle, a falling edge of addr_strobe (1 sampled, then 0) loads ch_addr into ch_sel at that edge. ch_sel ranges over 0 to 7.
- R9: A falling edge of addr_strobe while busy is high is ignored, and ch_sel keeps its value.
- R10: An active-low rst_n clears busy, step_en, the trial code, the stored result and ch_sel. It takes effect asynchronously, and its release is synchronised to clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_conv_n | input | 1 | 1 selects read, 0 selects convert |
| chip_en | input | 1 | Chip enable, active high |
| ch_addr | input | 3 | Channel address to be latched |
| addr_strobe | input | 1 | Address latch strobe; captures on its falling edge |
| cmp_ge | input | 1 | Comparator: 1 when the input is at or above trial_code |
| ch_sel | output | 3 | Latched channel select |
| busy | output | 1 | High while a conversion is in progress |
| step_en | output | 1 | Step clock enable for the converter |
| trial_code | output | 12 | Current successive-approximation code driven to the DAC |
| dout | output | 12 | Parallel result; zero when not enabled |
| dout_en | output | 1 | Output drive enable, stands in for the tri-state control |

## Verification
The bench builds the block with WIDTH = 12 and ACQ_CYCLES = 3. The short acquisition window makes the exact busy length, and the cycle in which the first trial code appears, easy to count. The full 12-bit width brings the extreme codes 0x000 and 0xFFF and the half-scale neighbours 0x7FF and 0x800 into the vector table. Each conversion contains a restart attempt, a read while busy and a strobe edge while busy. These land inside the conversion because the window is short. Every start order is used against different channels, so a wrong comparator routing or a wrong start trigger shows up as a wrong code or a wrong length.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_CONV = 2'd2
  } sar_state_t;
endpackage

// File: rtl/sar_rst_sync.sv
module sar_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/sar_chan_latch.sv
module sar_chan_latch #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic [AW-1:0] addr,
  input  logic          hold,
  output logic [AW-1:0] sel
);
  logic          strobe_q;
  logic [AW-1:0] sel_q, sel_d;
  logic          fall;

  assign fall = strobe_q && !strobe;

  always_comb begin
    sel_d = sel_q;
    if (fall && !hold) sel_d = addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      sel_q    <= '0;
    end else begin
      strobe_q <= strobe;
      sel_q    <= sel_d;
    end
  end

  assign sel = sel_q;

  // R9: channel held during a conversion
  assert_hold_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(sel));
endmodule

// File: rtl/sar_engine.sv
module sar_engine
  import sar_pkg::*;
#(
  parameter int WIDTH      = 12,
  parameter int ACQ_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cmp_ge,
  output logic             busy,
  output logic [WIDTH-1:0] trial,
  output logic [WIDTH-1:0] result
);
  localparam int CW = (ACQ_CYCLES > 1) ? $clog2(ACQ_CYCLES) : 1;
  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0]    ACQ_LAST = CW'(ACQ_CYCLES - 1);
  localparam logic [IW-1:0]    TOP_IDX  = IW'(WIDTH - 1);
  localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  sar_state_t       state_q, state_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [IW-1:0]    idx_q, idx_d;
  logic [WIDTH-1:0] sar_q, sar_d;
  logic [WIDTH-1:0] res_q, res_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    sar_d   = sar_q;
    res_d   = res_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_ACQ;
          cnt_d   = '0;
          sar_d   = '0;
        end
      end
      ST_ACQ: begin
        if (cnt_q == ACQ_LAST) begin
          state_d = ST_CONV;
          sar_d   = MSB_ONLY;
          idx_d   = TOP_IDX;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_CONV: begin
        sar_d[idx_q] = cmp_ge;
        if (idx_q == '0) begin
          state_d = ST_IDLE;
          res_d   = sar_d;
        end else begin
          sar_d[idx_q - 1'b1] = 1'b1;
          idx_d = idx_q - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sar_q   <= '0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      sar_q   <= sar_d;
      res_q   <= res_d;
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign trial  = sar_q;
  assign result = res_q;

  // R4: trial code cleared on start
  assert_clear_on_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start) |=> (busy && trial == '0));

  // R4: acquisition keeps zero, then MSB trial
  assert_first_trial_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACQ) |=> (trial == '0 || trial == MSB_ONLY));

  // R3: start during acquisition does not rewind the window
  assert_no_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACQ && start) |=> (state_q == ST_CONV || cnt_q != '0));

  // R5: decided bit follows the comparator
  assert_bit_decide_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONV) |=> (trial[$past(idx_q)] == $past(cmp_ge)));

  // R7: result only moves at the final step
  assert_result_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(state_q == ST_CONV && idx_q == '0) |=> $stable(result));
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int WIDTH      = 12,
  parameter int AW         = 3,
  parameter int ACQ_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_conv_n,
  input  logic             chip_en,
  input  logic [AW-1:0]    ch_addr,
  input  logic             addr_strobe,
  input  logic             cmp_ge,
  output logic [AW-1:0]    ch_sel,
  output logic             busy,
  output logic             step_en,
  output logic [WIDTH-1:0] trial_code,
  output logic [WIDTH-1:0] dout,
  output logic             dout_en
);
  logic             srst_n;
  logic             conv_req, conv_req_q, start;
  logic             busy_w;
  logic [WIDTH-1:0] result_w;

  sar_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign conv_req = !rd_conv_n && chip_en;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) conv_req_q <= 1'b0;
    else         conv_req_q <= conv_req;
  end

  assign start = conv_req && !conv_req_q;

  sar_engine #(.WIDTH(WIDTH), .ACQ_CYCLES(ACQ_CYCLES)) u_engine (
    .clk    (clk),
    .rst_n  (srst_n),
    .start  (start),
    .cmp_ge (cmp_ge),
    .busy   (busy_w),
    .trial  (trial_code),
    .result (result_w)
  );

  sar_chan_latch #(.AW(AW)) u_chan (
    .clk    (clk),
    .rst_n  (srst_n),
    .strobe (addr_strobe),
    .addr   (ch_addr),
    .hold   (busy_w),
    .sel    (ch_sel)
  );

  assign busy    = busy_w;
  assign step_en = busy_w;
  assign dout_en = rd_conv_n && chip_en;
  assign dout    = dout_en ? result_w : '0;

  // R1: a fresh request while idle begins a conversion
  assert_start_R1: assert property (@(posedge clk) disable iff (!srst_n)
    (!busy_w && !rd_conv_n && chip_en && !conv_req_q) |=> busy);

  // R1: no conversion begins without a request
  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!srst_n)
    (!busy_w && !(!rd_conv_n && chip_en)) |=> !busy);
endmodule

// File: tb/sar_conv_ctrl_test.sv
module sar_conv_ctrl_test;
  localparam int PERIOD = 10;
  localparam int W      = 12;
  localparam int ACQ    = 3;
  localparam int NVEC   = 8;

  logic         clk = 1'b0;
  logic         rst_n, rd_conv_n, chip_en, addr_strobe;
  logic [2:0]   ch_addr, ch_sel;
  logic         busy, step_en, dout_en, cmp_ge;
  logic [W-1:0] trial_code, dout;
  logic [W-1:0] vin_arr [8];
  logic [W-1:0] prev;
  int total = 0;
  int bad   = 0;

  // vector: mode(0 CE last, 1 RC last, 2 together), channel, input code
  localparam logic [16:0] VECS [NVEC] = '{
    {2'd0, 3'd0, 12'h000},
    {2'd1, 3'd7, 12'hFFF},
    {2'd2, 3'd3, 12'h800},
    {2'd0, 3'd4, 12'h7FF},
    {2'd1, 3'd1, 12'hA5C},
    {2'd2, 3'd6, 12'h001},
    {2'd0, 3'd2, 12'h3E9},
    {2'd1, 3'd5, 12'hFFE}
  };

  always #(PERIOD/2) clk = ~clk;

  assign cmp_ge = (vin_arr[ch_sel] >= trial_code);

  sar_conv_ctrl #(.WIDTH(W), .AW(3), .ACQ_CYCLES(ACQ)) uut (
    .clk(clk), .rst_n(rst_n), .rd_conv_n(rd_conv_n), .chip_en(chip_en),
    .ch_addr(ch_addr), .addr_strobe(addr_strobe), .cmp_ge(cmp_ge),
    .ch_sel(ch_sel), .busy(busy), .step_en(step_en), .trial_code(trial_code),
    .dout(dout), .dout_en(dout_en)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic latch_chan(input logic [2:0] ch);
    @(negedge clk); ch_addr = ch; addr_strobe = 1'b1;
    @(negedge clk); addr_strobe = 1'b0;
    @(negedge clk);
    check(ch_sel == ch, "R8 channel latch", ch_sel, ch);
  endtask

  task automatic run_conv(input logic [1:0] mode, input logic [2:0] ch, input logic [W-1:0] vin);
    int n;
    vin_arr[ch] = vin;
    latch_chan(ch);
    case (mode)
      2'd0: begin
        rd_conv_n = 1'b0;
        @(negedge clk);
        check(!dout_en && dout == '0, "R6 convert select alone", dout_en, 0);
        check(!busy, "R1 convert select alone", busy, 0);
        chip_en = 1'b1;
      end
      2'd1: begin
        chip_en = 1'b1;
        @(negedge clk);
        check(dout_en && dout == prev, "R6 read enabled", dout, prev);
        check(!busy, "R1 chip enable alone", busy, 0);
        rd_conv_n = 1'b0;
      end
      default: begin
        rd_conv_n = 1'b0; chip_en = 1'b1;
      end
    endcase
    n = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (!busy) break;
      n++;
      if (n == 1) check(trial_code == '0, "R4 cleared at start", trial_code, 0);
      if (n == ACQ + 1) check(trial_code == 12'h800, "R4 first trial", trial_code, 12'h800);
      if (n == 2) begin
        rd_conv_n = 1'b1; addr_strobe = 1'b1; ch_addr = ch ^ 3'd1;
      end
      if (n == 3) begin
        check(dout_en && dout == prev, "R7 read while busy", dout, prev);
        rd_conv_n = 1'b0; addr_strobe = 1'b0;
      end
      if (n == 5) check(ch_sel == ch, "R9 strobe while busy", ch_sel, ch);
    end
    check(n == ACQ + W, "R2 busy length", n, ACQ + W);
    check(!step_en, "R2 step enable off", step_en, 0);
    repeat (3) @(negedge clk);
    check(!busy, "R3 held request no restart", busy, 0);
    rd_conv_n = 1'b1;
    @(negedge clk);
    check(dout_en && dout == vin, "R5 final code", dout, vin);
    chip_en = 1'b0;
    @(negedge clk);
    check(!dout_en && dout == '0, "R6 output off", dout, 0);
    prev = vin;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) vin_arr[i] = '0;
    prev = '0;
    rst_n = 1'b0; rd_conv_n = 1'b1; chip_en = 1'b0; addr_strobe = 1'b0; ch_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !step_en, "R10 reset busy", busy, 0);
    check(trial_code == '0, "R10 reset trial", trial_code, 0);
    check(ch_sel == '0, "R10 reset channel", ch_sel, 0);
    chip_en = 1'b1;
    @(negedge clk);
    check(dout_en && dout == '0, "R10 reset result", dout, 0);
    chip_en = 1'b0;

    for (int v = 0; v < NVEC; v++)
      run_conv(VECS[v][16:15], VECS[v][14:12], VECS[v][11:0]);

    // mid-conversion reset
    latch_chan(3'd5);
    rd_conv_n = 1'b0; chip_en = 1'b1;
    repeat (5) @(negedge clk);
    check(busy, "R2 busy before reset", busy, 1);
    rst_n = 1'b0; rd_conv_n = 1'b1; chip_en = 1'b0;
    @(negedge clk);
    check(!busy, "R10 async reset", busy, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(trial_code == '0 && ch_sel == '0, "R10 reset mid run", trial_code, 0);
    chip_en = 1'b1;
    @(negedge clk);
    check(dout == '0, "R10 result cleared", dout, 0);
    chip_en = 1'b0;
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule